// File: doc/BRIEF.md
# Receive Buffer Descriptor Filler

The block accepts one received frame at a time as a byte stream and lays it out across receive buffers owned by a ring of descriptors. For every byte it places in memory it issues a single-byte write request. When a buffer is closed it issues one descriptor update that carries the byte length and the status flags. Bytes that do not come from the stream are generated inside the block. An optional 10-byte control header is placed ahead of the data. Four zero bytes are reserved for the CRC after the data. Frames shorter than the Ethernet minimum get extra zero bytes. All of these bytes count toward the length of the buffer that holds them.

The descriptor under the ring pointer is read through a same-cycle lookup port: the block presents `desc_addr`, and the surrounding memory returns that descriptor's empty flag, wrap flag and buffer pointer. No buffer holds more bytes than the programmed maximum; the rest of the frame continues in the next descriptor. A descriptor carrying the wrap flag sends the pointer back to the ring base. If the block must open a descriptor that software has not handed back (empty flag clear), it raises a one-cycle busy pulse. It then discards the rest of the frame.

Top module: `rx_desc_filler`

## Requirements
- R1: While the frame is accepted, a nonzero `cfg_parse_depth` places 10 zero bytes ahead of the first data byte. A zero value places none. The value is sampled when the first byte of the frame is offered.
- R2: Four zero bytes follow the data of every frame. They are written like any other byte and counted in the descriptor length.
- R3: A frame of n < 60 data bytes gets 60 − n zero bytes between its data and the four CRC bytes. A frame of 60 or more bytes gets no such bytes.
- R4: A buffer never receives more than `cfg_max_len` bytes. When a buffer fills and bytes remain, the buffer is closed and the remaining bytes go to the next descriptor, starting at offset 0 of that descriptor's buffer.
- R5: Bytes are written one per cycle, in stream order: header, then data, then padding, then CRC. Each byte goes to address `desc_buf` plus its offset within the current buffer.
- R6: Each descriptor update reports as its length the number of bytes written into that buffer. It reports the empty flag as cleared (`upd_empty` = 0).
- R7: After reset, `desc_addr` equals `cfg_ring_base` with bits [2:0] forced to zero. It always has bits [2:0] zero, and it advances by 8 after each closed descriptor.
- R8: `upd_last` is 1 only on the update of the buffer that holds the frame's final byte. That buffer may hold only padding or CRC bytes.
- R9: After a descriptor whose wrap flag is set is closed, `desc_addr` returns to the aligned ring base.
- R10: If a descriptor whose empty flag is 0 must be opened (frame start or spill), no byte is written to it and `busy` pulses for one cycle. The rest of the frame is then accepted and discarded, and `desc_addr` stays on that descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_parse_depth | input | PD_W | Nonzero enables the 10-byte control header |
| cfg_max_len | input | LEN_W | Maximum bytes per buffer (at least 1) |
| cfg_ring_base | input | ADDR_W | Ring base address; bits [2:0] ignored |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Marks the final data byte of the frame |
| in_ready | output | 1 | Stream byte accepted when high together with in_valid |
| desc_addr | output | ADDR_W | Address of the current descriptor |
| desc_empty | input | 1 | Current descriptor is owned by the block |
| desc_wrap | input | 1 | Current descriptor is the last in the ring |
| desc_buf | input | ADDR_W | Buffer pointer of the current descriptor |
| wr_valid | output | 1 | Byte write request |
| wr_addr | output | ADDR_W | Byte write address |
| wr_data | output | 8 | Byte write data |
| upd_valid | output | 1 | Descriptor update request |
| upd_addr | output | ADDR_W | Address of the descriptor being updated |
| upd_len | output | LEN_W | Bytes written into that buffer |
| upd_last | output | 1 | Buffer holds the frame's final byte |
| upd_empty | output | 1 | Empty flag written back (0 once data is written) |
| busy | output | 1 | One-cycle pulse when a frame is dropped |

## Verification
The frames cover several shapes. A 64-byte frame with no header tells CRC accounting apart from short-frame padding. Short frames with and without the header show that generated bytes count toward the length. A long frame with a small buffer limit spills across the whole ring and wraps. Frames placed so that the split lands after the last data byte, or exactly on the frame end, check where the last flag goes. Ring states with a descriptor not handed back, met at frame start and in the middle of the padding, show that the drop path leaves the pointer in place. Every write and update is compared in order against queues built from the requirements.

// File: rtl/rdf_pkg.sv
package rdf_pkg;

    localparam int unsigned HDR_BYTES   = 10;
    localparam int unsigned CRC_BYTES   = 4;
    localparam int unsigned MIN_DATA    = 60;
    localparam int unsigned DESC_STRIDE = 8;
    localparam int unsigned CNT_W       = 7;
    localparam int unsigned HDR_W       = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_DATA,
        ST_PAD,
        ST_DROP
    } fill_state_e;

    typedef struct packed {
        logic emit;   // one byte written this cycle
        logic close;  // current buffer ends with this byte
        logic last;   // this byte ends the frame
    } fill_step_t;

    // zero bytes that follow n data bytes: short-frame fill plus CRC room
    function automatic logic [CNT_W-1:0] tail_bytes(input logic [CNT_W-1:0] n);
        if (n >= CNT_W'(MIN_DATA))
            return CNT_W'(CRC_BYTES);
        return CNT_W'(MIN_DATA) - n + CNT_W'(CRC_BYTES);
    endfunction

endpackage

// File: rtl/rdf_ring_ptr.sv
module rdf_ring_ptr
    import rdf_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] base,
    input  logic              advance,
    input  logic              wrap,
    output logic [ADDR_W-1:0] ptr
);
    logic [ADDR_W-1:0] base_al;

    assign base_al = {base[ADDR_W-1:3], 3'b000};

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= base_al;
        else if (advance)
            ptr <= wrap ? base_al : ptr + ADDR_W'(DESC_STRIDE);
    end
endmodule

// File: rtl/rdf_ctrl.sv
module rdf_ctrl
    import rdf_pkg::*;
#(
    parameter int unsigned LEN_W = 16,
    parameter int unsigned PD_W  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PD_W-1:0]  cfg_parse_depth,
    input  logic [LEN_W-1:0] cfg_max_len,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic             desc_empty,
    output logic             in_ready,
    output logic             data_sel,
    output logic             busy,
    output fill_step_t       step,
    output logic [LEN_W-1:0] buf_off
);
    fill_state_e      state_q;
    logic [LEN_W-1:0] len_q;
    logic [HDR_W-1:0] hdr_q;
    logic [CNT_W-1:0] pad_q;
    logic [CNT_W-1:0] cnt_q;

    logic             open_ok;
    logic             want;
    logic             more;
    logic [LEN_W-1:0] len_nx;
    logic [CNT_W-1:0] cnt_nx;

    always_comb begin
        open_ok   = (len_q != '0) || desc_empty;
        want      = (state_q == ST_HDR) || (state_q == ST_PAD)
                  || ((state_q == ST_DATA) && in_valid);
        more      = (state_q != ST_PAD) || (pad_q > CNT_W'(1));
        len_nx    = len_q + LEN_W'(1);
        cnt_nx    = (cnt_q >= CNT_W'(MIN_DATA)) ? cnt_q : cnt_q + CNT_W'(1);
        step.emit  = want && open_ok;
        step.close = step.emit && ((len_nx >= cfg_max_len) || !more);
        step.last  = step.emit && !more;
        busy      = want && !open_ok;
        in_ready  = ((state_q == ST_DATA) && open_ok) || (state_q == ST_DROP);
        data_sel  = (state_q == ST_DATA);
        buf_off   = len_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            len_q   <= '0;
            hdr_q   <= '0;
            pad_q   <= '0;
            cnt_q   <= '0;
        end else begin
            if (step.emit)
                len_q <= step.close ? '0 : len_nx;
            unique case (state_q)
                ST_IDLE: begin
                    if (in_valid) begin
                        cnt_q   <= '0;
                        hdr_q   <= HDR_W'(HDR_BYTES);
                        state_q <= (cfg_parse_depth != '0) ? ST_HDR : ST_DATA;
                    end
                end
                ST_HDR: begin
                    if (busy)
                        state_q <= ST_DROP;
                    else if (step.emit) begin
                        hdr_q <= hdr_q - HDR_W'(1);
                        if (hdr_q == HDR_W'(1))
                            state_q <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (busy)
                        state_q <= ST_DROP;
                    else if (step.emit) begin
                        cnt_q <= cnt_nx;
                        if (in_last) begin
                            pad_q   <= tail_bytes(cnt_nx);
                            state_q <= ST_PAD;
                        end
                    end
                end
                ST_PAD: begin
                    if (busy)
                        state_q <= ST_IDLE;
                    else if (step.emit) begin
                        pad_q <= pad_q - CNT_W'(1);
                        if (pad_q == CNT_W'(1))
                            state_q <= ST_IDLE;
                    end
                end
                ST_DROP: begin
                    if (in_valid && in_last)
                        state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rdf_write_port.sv
module rdf_write_port
    import rdf_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LEN_W  = 16
) (
    input  fill_step_t        step,
    input  logic              data_sel,
    input  logic [7:0]        in_data,
    input  logic [ADDR_W-1:0] desc_buf,
    input  logic [ADDR_W-1:0] desc_addr,
    input  logic [LEN_W-1:0]  buf_off,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              upd_valid,
    output logic [ADDR_W-1:0] upd_addr,
    output logic [LEN_W-1:0]  upd_len,
    output logic              upd_last,
    output logic              upd_empty
);
    logic [ADDR_W-1:0] off_ext;

    always_comb begin
        off_ext   = ADDR_W'(buf_off);
        wr_valid  = step.emit;
        wr_addr   = desc_buf + off_ext;
        wr_data   = data_sel ? in_data : 8'h00;
        upd_valid = step.close;
        upd_addr  = desc_addr;
        upd_len   = buf_off + LEN_W'(1);
        upd_last  = step.last;
        upd_empty = (upd_len == '0);
    end
endmodule

// File: rtl/rx_desc_filler.sv
module rx_desc_filler
    import rdf_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LEN_W  = 16,
    parameter int unsigned PD_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PD_W-1:0]   cfg_parse_depth,
    input  logic [LEN_W-1:0]  cfg_max_len,
    input  logic [ADDR_W-1:0] cfg_ring_base,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic [ADDR_W-1:0] desc_addr,
    input  logic              desc_empty,
    input  logic              desc_wrap,
    input  logic [ADDR_W-1:0] desc_buf,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              upd_valid,
    output logic [ADDR_W-1:0] upd_addr,
    output logic [LEN_W-1:0]  upd_len,
    output logic              upd_last,
    output logic              upd_empty,
    output logic              busy
);
    fill_step_t       step;
    logic             data_sel;
    logic [LEN_W-1:0] buf_off;

    rdf_ctrl #(.LEN_W(LEN_W), .PD_W(PD_W)) u_ctrl (
        .clk             (clk),
        .rst             (rst),
        .cfg_parse_depth (cfg_parse_depth),
        .cfg_max_len     (cfg_max_len),
        .in_valid        (in_valid),
        .in_last         (in_last),
        .desc_empty      (desc_empty),
        .in_ready        (in_ready),
        .data_sel        (data_sel),
        .busy            (busy),
        .step            (step),
        .buf_off         (buf_off)
    );

    rdf_ring_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .base    (cfg_ring_base),
        .advance (step.close),
        .wrap    (desc_wrap),
        .ptr     (desc_addr)
    );

    rdf_write_port #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_wport (
        .step      (step),
        .data_sel  (data_sel),
        .in_data   (in_data),
        .desc_buf  (desc_buf),
        .desc_addr (desc_addr),
        .buf_off   (buf_off),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .upd_valid (upd_valid),
        .upd_addr  (upd_addr),
        .upd_len   (upd_len),
        .upd_last  (upd_last),
        .upd_empty (upd_empty)
    );
endmodule

// File: rtl/rdf_checker.sv
module rdf_checker #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LEN_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [LEN_W-1:0]  cfg_max_len,
    input logic [ADDR_W-1:0] cfg_ring_base,
    input logic [ADDR_W-1:0] desc_addr,
    input logic              desc_wrap,
    input logic              wr_valid,
    input logic              upd_valid,
    input logic [LEN_W-1:0]  upd_len,
    input logic              upd_last,
    input logic              upd_empty,
    input logic              busy
);
    AST_LEN_LIMIT: assert property (@(posedge clk) disable iff (rst)
        upd_valid |-> (upd_len <= cfg_max_len) && (upd_len != '0)); // R4
    AST_UPD_WITH_WRITE: assert property (@(posedge clk) disable iff (rst)
        upd_valid |-> wr_valid); // R5
    AST_EMPTY_CLEARED: assert property (@(posedge clk) disable iff (rst)
        upd_valid |-> !upd_empty); // R6
    AST_DESC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        desc_addr[2:0] == 3'b000); // R7
    AST_LAST_NEEDS_UPD: assert property (@(posedge clk) disable iff (rst)
        upd_last |-> upd_valid); // R8
    AST_WRAP_TO_BASE: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && desc_wrap) |=> desc_addr == {cfg_ring_base[ADDR_W-1:3], 3'b000}); // R9
    AST_BUSY_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        busy |-> !wr_valid); // R10
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!upd_valid && !$past(rst)) |=> $stable(desc_addr)); // R10
endmodule

bind rx_desc_filler rdf_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cfg_max_len   (cfg_max_len),
    .cfg_ring_base (cfg_ring_base),
    .desc_addr     (desc_addr),
    .desc_wrap     (desc_wrap),
    .wr_valid      (wr_valid),
    .upd_valid     (upd_valid),
    .upd_len       (upd_len),
    .upd_last      (upd_last),
    .upd_empty     (upd_empty),
    .busy          (busy)
);

// File: tb/rx_desc_filler_tb.sv
module rx_desc_filler_tb;
    localparam int NDESC = 4;
    localparam int BASE  = 32'h1000;
    localparam int BUFB  = 32'h8000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_parse_depth = '0;
    logic [15:0] cfg_max_len = 16'd2048;
    logic [31:0] cfg_ring_base = 32'h0000_1005;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic [31:0] desc_addr;
    logic        desc_empty;
    logic        desc_wrap;
    logic [31:0] desc_buf;
    logic        wr_valid;
    logic [31:0] wr_addr;
    logic [7:0]  wr_data;
    logic        upd_valid;
    logic [31:0] upd_addr;
    logic [15:0] upd_len;
    logic        upd_last;
    logic        upd_empty;
    logic        busy;

    always #5 clk = ~clk;

    rx_desc_filler u_dut (
        .clk(clk), .rst(rst), .cfg_parse_depth(cfg_parse_depth),
        .cfg_max_len(cfg_max_len), .cfg_ring_base(cfg_ring_base),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_ready(in_ready), .desc_addr(desc_addr), .desc_empty(desc_empty),
        .desc_wrap(desc_wrap), .desc_buf(desc_buf), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .upd_valid(upd_valid),
        .upd_addr(upd_addr), .upd_len(upd_len), .upd_last(upd_last),
        .upd_empty(upd_empty), .busy(busy)
    );

    // descriptor memory seen by the block
    bit mem_empty [NDESC];
    logic [1:0] cur_idx;
    assign cur_idx    = desc_addr[4:3];
    assign desc_empty = mem_empty[cur_idx];
    assign desc_wrap  = (cur_idx == 2'(NDESC - 1));
    assign desc_buf   = BUFB + {22'd0, cur_idx, 8'h00};

    always @(posedge clk)
        if (upd_valid) mem_empty[cur_idx] <= 1'b0;

    // reference model state and expected event queues
    bit      m_empty [NDESC];
    int      m_ptr;
    int      exp_wa[$];
    int      exp_wd[$];
    int      exp_ua[$];
    int      exp_ul[$];
    bit      exp_last[$];
    int      exp_busy;
    int      act_busy;
    int      n_checks;
    int      n_fail;
    string   tag;
    bit      done;

    task automatic chk(input bit ok, input string t, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
        end
    endtask

    function automatic int dbyte(input int seed, input int k);
        return (seed + k * 7) & 8'hFF;
    endfunction

    task automatic build_expect(input int n, input int pd, input int seed);
        int h, total, len, idx, b;
        h     = (pd != 0) ? 10 : 0;
        total = h + n + ((n < 60) ? 60 - n : 0) + 4;
        len   = 0;
        for (int i = 0; i < total; i++) begin
            idx = (m_ptr - BASE) >> 3;
            if (len == 0 && !m_empty[idx]) begin
                exp_busy++;
                break;
            end
            b = (i < h) ? 0 : (i < h + n) ? dbyte(seed, i - h) : 0;
            exp_wa.push_back(BUFB + idx * 256 + len);
            exp_wd.push_back(b);
            len++;
            if (len == int'(cfg_max_len) || i == total - 1) begin
                exp_ua.push_back(m_ptr);
                exp_ul.push_back(len);
                exp_last.push_back(i == total - 1);
                m_empty[idx] = 1'b0;
                m_ptr = (idx == NDESC - 1) ? BASE : m_ptr + 8;
                len = 0;
            end
        end
    endtask

    // compared on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (busy) act_busy++;
            if (wr_valid) begin
                if (exp_wa.size() == 0)
                    chk(1'b0, "R5", "unexpected write", wr_addr, 0);
                else begin
                    int a, d;
                    a = exp_wa.pop_front();
                    d = exp_wd.pop_front();
                    chk(wr_addr == 32'(a), "R5", "write address", wr_addr, a);
                    chk(wr_data == 8'(d), tag, "write data", wr_data, d);
                end
            end
            if (upd_valid) begin
                if (exp_ua.size() == 0)
                    chk(1'b0, "R4", "unexpected update", upd_addr, 0);
                else begin
                    int a, l;
                    bit ls;
                    a  = exp_ua.pop_front();
                    l  = exp_ul.pop_front();
                    ls = exp_last.pop_front();
                    chk(upd_addr == 32'(a), "R7", "update address", upd_addr, a);
                    chk(upd_len == 16'(l), tag, "update length", upd_len, l);
                    chk(upd_last == ls, "R8", "last flag", upd_last, ls);
                    chk(upd_empty == 1'b0, "R6", "empty flag", upd_empty, 0);
                end
            end
        end
    end

    task automatic rearm();
        for (int i = 0; i < NDESC; i++) begin
            mem_empty[i] = 1'b1;
            m_empty[i]   = 1'b1;
        end
    endtask

    task automatic send_frame(input string t, input int n, input int pd, input int seed);
        bit acc;
        tag = t;
        cfg_parse_depth = 2'(pd);
        exp_busy = 0;
        act_busy = 0;
        build_expect(n, pd, seed);
        for (int k = 0; k < n; k++) begin
            in_valid = 1'b1;
            in_data  = 8'(dbyte(seed, k));
            in_last  = (k == n - 1);
            do begin
                @(negedge clk);
                acc = in_ready;
                @(posedge clk);
                #1;
            end while (!acc);
            if (k % 7 == 6) begin
                in_valid = 1'b0;
                @(posedge clk);
                #1;
            end
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        repeat (120) @(posedge clk);
        #1;
        chk(exp_wa.size() == 0, t, "missing writes", exp_wa.size(), 0);
        chk(exp_ua.size() == 0, t, "missing updates", exp_ua.size(), 0);
        chk(act_busy == exp_busy, "R10", "busy pulses", act_busy, exp_busy);
        chk(desc_addr == 32'(m_ptr), "R9", "descriptor pointer", desc_addr, m_ptr);
        exp_wa.delete(); exp_wd.delete(); exp_ua.delete();
        exp_ul.delete(); exp_last.delete();
    endtask

    initial begin
        n_checks = 0;
        n_fail   = 0;
        done     = 0;
        tag      = "R5";
        m_ptr    = BASE;
        rearm();
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        chk(desc_addr == 32'h1000, "R7", "reset pointer", desc_addr, 32'h1000);
        chk(!wr_valid && !upd_valid && !busy, "R7", "reset outputs idle",
            {wr_valid, upd_valid, busy}, 0);
        chk(in_ready == 1'b0, "R7", "reset in_ready", in_ready, 0);
        @(posedge clk);
        #1;

        cfg_max_len = 16'd2048;
        send_frame("R2", 64, 0, 3);      // 68 bytes, CRC only
        send_frame("R3", 20, 0, 9);      // 64 bytes with fill
        send_frame("R1", 20, 1, 17);     // 74 bytes with header
        send_frame("R9", 3, 0, 40);      // wrap descriptor, back to base
        chk(desc_addr == 32'h1000, "R9", "pointer after wrap", desc_addr, 32'h1000);
        send_frame("R10", 12, 0, 5);     // descriptor 0 not handed back
        chk(desc_addr == 32'h1000, "R10", "pointer held after drop", desc_addr, 32'h1000);

        rearm();
        cfg_max_len = 16'd32;
        send_frame("R4", 100, 2, 77);    // 114 bytes over four buffers
        rearm();
        cfg_max_len = 16'd62;
        send_frame("R8", 58, 0, 21);     // last buffer holds only tail bytes
        mem_empty[2] = 1'b1; m_empty[2] = 1'b1;
        mem_empty[3] = 1'b1; m_empty[3] = 1'b1;
        cfg_max_len = 16'd16;
        send_frame("R10", 30, 0, 55);    // dropped inside the tail bytes
        rearm();
        cfg_max_len = 16'd64;
        send_frame("R3", 60, 0, 88);     // exactly fills one buffer
        send_frame("R4", 61, 0, 101);    // one byte spills

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule